// File: doc/BRIEF.md
# Operand Address Generator

This block turns a decoded addressing mode into an operand and the address that operand came from. The caller presents the mode code, the address field of the instruction, the content of the named register, the program counter (already advanced past the current instruction), the index and base register values and an operand size. It then pulses `start`. The block forms the effective address. When the mode needs memory, it fetches the operand through a request/response read port. It then pulses `done` with the results.

A mode can require a second read. In that case the first word read is taken as the real effective address, and a second read fetches the operand. Modes that move their pointer register also report the new register value. For post-increment the pointer moves after it has been used as the address. For pre-decrement the pointer moves first, and the moved value is the address. In both cases the block raises a write-back strobe together with `done`, so the caller can update its register file.

Top module: `opaddr_gen`

## Requirements
- R1: After reset `done`, `busy`, `mem_req` and `wb_valid` are low.
- R2: Mode 0 (immediate), and any code from 10 to 15, returns the zero-extended address field as operand. The effective address is 0 and no memory read is made.
- R3: Mode 3 (register) returns `reg_val` as operand. The effective address is 0 and no memory read is made.
- R4: Mode 1 (direct) uses the address field as effective address. Exactly one read is made, and the word read is the operand.
- R5: Mode 2 (memory indirect) first reads the word at the address field. The low address bits of that word become the effective address, and a second read at it returns the operand. Exactly two reads are made.
- R6: Mode 4 (register indirect) uses `reg_val` as effective address, with one read.
- R7: Mode 5 (PC-relative) uses `pc` plus the address field, modulo 2^AW, with one read.
- R8: Mode 6 adds `index_val` to the address field, and mode 7 adds `base_val` to the address field. Each makes one read at the sum.
- R9: Mode 8 (post-increment) uses `reg_val` as effective address. It reports `wb_value = reg_val + d` for register `reg_sel`.
- R10: Mode 9 (pre-decrement) uses `reg_val - d` as effective address and reports that same value for write-back.
- R11: The step d is selected by `size_sel`: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4.
- R12: While `mem_req` is high and no `mem_rvalid` has arrived, `mem_addr` and `mem_req` stay unchanged.
- R13: `done` is a one-cycle pulse, and `wb_valid` is only ever high together with it. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| size_sel | input | 2 | Operand size select for the step d |
| addr_field | input | AW | Address/operand field of the instruction |
| reg_sel | input | RIW | Number of the named register |
| reg_val | input | DW | Content of the named register |
| pc | input | AW | Program counter, already advanced |
| index_val | input | AW | Index register value |
| base_val | input | AW | Base register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid this cycle |
| operand | output | DW | Fetched or immediate operand |
| eff_addr | output | AW | Effective address |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| wb_valid | output | 1 | Pointer write-back strobe |
| wb_reg | output | RIW | Register to write back |
| wb_value | output | DW | Updated pointer value |

## Verification
The hardest case to reach is the chained read of memory indirect mode. The second address comes from the data of the first response. The memory must therefore answer two requests back to back, with a random latency on each, and the bench must watch that the request stays unbroken across both. The bench memory returns a scrambled function of the address, so every word read differs from its address and the second address is checked independently. A directed case starts a new operation while one is in flight and counts the `done` pulses to prove the second `start` was ignored.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [3:0] {
      AM_IMM   = 4'd0,
      AM_DIR   = 4'd1,
      AM_IND   = 4'd2,
      AM_REG   = 4'd3,
      AM_RIND  = 4'd4,
      AM_PCREL = 4'd5,
      AM_IDX   = 4'd6,
      AM_BASE  = 4'd7,
      AM_POST  = 4'd8,
      AM_PRE   = 4'd9
   } am_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD1  = 2'd1,
      ST_RD2  = 2'd2,
      ST_FIN  = 2'd3
   } ctl_state_e;

   function automatic logic [2:0] step_of(input logic [1:0] sz);
      case (sz)
         2'd0:    step_of = 3'd1;
         2'd1:    step_of = 3'd2;
         default: step_of = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/opaddr_calc.sv
module opaddr_calc
   import opaddr_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic [3:0]    mode,
   input  logic [1:0]    size_sel,
   input  logic [AW-1:0] addr_field,
   input  logic [DW-1:0] reg_val,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] index_val,
   input  logic [AW-1:0] base_val,
   output logic [AW-1:0] first_addr,
   output logic          needs_mem,
   output logic          indirect,
   output logic          wb_en,
   output logic [DW-1:0] wb_val,
   output logic [DW-1:0] direct_operand
);

   localparam int PAD = (DW > AW) ? DW - AW : 1;

   logic [DW-1:0] field_ext;
   logic [DW-1:0] step_ext;
   logic [DW-1:0] ptr_up;
   logic [DW-1:0] ptr_dn;

   generate
      if (DW > AW) begin : g_ext
         assign field_ext = {{PAD{1'b0}}, addr_field};
      end else begin : g_same
         assign field_ext = addr_field[DW-1:0];
      end
   endgenerate

   assign step_ext = DW'(step_of(size_sel));
   assign ptr_up   = reg_val + step_ext;
   assign ptr_dn   = reg_val - step_ext;

   always_comb begin
      first_addr     = '0;
      needs_mem      = 1'b1;
      indirect       = 1'b0;
      wb_en          = 1'b0;
      wb_val         = '0;
      direct_operand = '0;
      case (mode)
         AM_IMM: begin
            needs_mem      = 1'b0;
            direct_operand = field_ext;
         end
         AM_DIR:   first_addr = addr_field;
         AM_IND: begin
            first_addr = addr_field;
            indirect   = 1'b1;
         end
         AM_REG: begin
            needs_mem      = 1'b0;
            direct_operand = reg_val;
         end
         AM_RIND:  first_addr = reg_val[AW-1:0];
         AM_PCREL: first_addr = pc + addr_field;
         AM_IDX:   first_addr = index_val + addr_field;
         AM_BASE:  first_addr = base_val + addr_field;
         AM_POST: begin
            first_addr = reg_val[AW-1:0];
            wb_en      = 1'b1;
            wb_val     = ptr_up;
         end
         AM_PRE: begin
            first_addr = ptr_dn[AW-1:0];
            wb_en      = 1'b1;
            wb_val     = ptr_dn;
         end
         default: begin
            needs_mem      = 1'b0;
            direct_operand = field_ext;
         end
      endcase
   end

   // R9 / R10: the reported pointer differs from the register by exactly the step
   always_comb begin
      if (wb_en && mode == AM_POST)
         assert_post_step_R9: assert ((wb_val - reg_val) == step_ext);
      if (wb_en && mode == AM_PRE)
         assert_pre_addr_R10: assert (first_addr == wb_val[AW-1:0]);
   end

endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
   import opaddr_pkg::*;
#(
   parameter int AW  = 16,
   parameter int DW  = 16,
   parameter int RIW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           needs_mem,
   input  logic           indirect,
   input  logic [AW-1:0]  first_addr,
   input  logic [DW-1:0]  direct_operand,
   input  logic           wb_en,
   input  logic [DW-1:0]  wb_val,
   input  logic [RIW-1:0] wb_sel,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata,
   output logic           busy,
   output logic           done,
   output logic [DW-1:0]  operand,
   output logic [AW-1:0]  eff_addr,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   output logic           wb_valid,
   output logic [RIW-1:0] wb_reg,
   output logic [DW-1:0]  wb_value
);

   ctl_state_e state;
   logic       ind_q;
   logic       wb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ind_q    <= 1'b0;
         wb_q     <= 1'b0;
         operand  <= '0;
         eff_addr <= '0;
         mem_addr <= '0;
         wb_reg   <= '0;
         wb_value <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               ind_q    <= indirect;
               wb_q     <= wb_en;
               wb_reg   <= wb_sel;
               wb_value <= wb_val;
               if (needs_mem) begin
                  mem_addr <= first_addr;
                  eff_addr <= first_addr;
                  state    <= ST_RD1;
               end else begin
                  operand  <= direct_operand;
                  eff_addr <= '0;
                  state    <= ST_FIN;
               end
            end
            ST_RD1: if (mem_rvalid) begin
               if (ind_q) begin
                  mem_addr <= mem_rdata[AW-1:0];
                  eff_addr <= mem_rdata[AW-1:0];
                  state    <= ST_RD2;
               end else begin
                  operand <= mem_rdata;
                  state   <= ST_FIN;
               end
            end
            ST_RD2: if (mem_rvalid) begin
               operand <= mem_rdata;
               state   <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FIN);
   assign mem_req  = (state == ST_RD1) || (state == ST_RD2);
   assign wb_valid = done && wb_q;

   // R12: request and address held until a response arrives
   assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

   // R13: done lasts exactly one cycle
   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R13: write-back strobe only alongside done
   assert_wb_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);

   // R2 / R3: memory-free modes finish next cycle without a request
   assert_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !needs_mem |=> done && !mem_req);

   // R13: a start while busy does not disturb the pending request address
   assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
      start && mem_req && !mem_rvalid |=> $stable(mem_addr));

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opaddr_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int NREGS = 8,
   localparam int RIW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [3:0]     mode,
   input  logic [1:0]     size_sel,
   input  logic [AW-1:0]  addr_field,
   input  logic [RIW-1:0] reg_sel,
   input  logic [DW-1:0]  reg_val,
   input  logic [AW-1:0]  pc,
   input  logic [AW-1:0]  index_val,
   input  logic [AW-1:0]  base_val,
   output logic           busy,
   output logic           done,
   output logic [DW-1:0]  operand,
   output logic [AW-1:0]  eff_addr,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata,
   output logic           wb_valid,
   output logic [RIW-1:0] wb_reg,
   output logic [DW-1:0]  wb_value
);

   generate
      if (DW < AW) begin : g_bad_width
         $error("opaddr_gen: DW must be at least AW");
      end
      if (AW < 4) begin : g_bad_aw
         $error("opaddr_gen: AW must be at least 4");
      end
   endgenerate

   logic [AW-1:0] first_addr;
   logic          needs_mem;
   logic          indirect;
   logic          wb_en;
   logic [DW-1:0] wb_val;
   logic [DW-1:0] direct_operand;

   opaddr_calc #(.AW(AW), .DW(DW)) u_calc (
      .mode           (mode),
      .size_sel       (size_sel),
      .addr_field     (addr_field),
      .reg_val        (reg_val),
      .pc             (pc),
      .index_val      (index_val),
      .base_val       (base_val),
      .first_addr     (first_addr),
      .needs_mem      (needs_mem),
      .indirect       (indirect),
      .wb_en          (wb_en),
      .wb_val         (wb_val),
      .direct_operand (direct_operand)
   );

   opaddr_ctrl #(.AW(AW), .DW(DW), .RIW(RIW)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .needs_mem      (needs_mem),
      .indirect       (indirect),
      .first_addr     (first_addr),
      .direct_operand (direct_operand),
      .wb_en          (wb_en),
      .wb_val         (wb_val),
      .wb_sel         (reg_sel),
      .mem_rvalid     (mem_rvalid),
      .mem_rdata      (mem_rdata),
      .busy           (busy),
      .done           (done),
      .operand        (operand),
      .eff_addr       (eff_addr),
      .mem_req        (mem_req),
      .mem_addr       (mem_addr),
      .wb_valid       (wb_valid),
      .wb_reg         (wb_reg),
      .wb_value       (wb_value)
   );

   // R1: nothing active while reset is held
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !done && !mem_req && !wb_valid);

endmodule

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;

   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = '0;
   logic [1:0]    size_sel = '0;
   logic [AW-1:0] addr_field = '0;
   logic [2:0]    reg_sel = '0;
   logic [DW-1:0] reg_val = '0;
   logic [AW-1:0] pc = '0;
   logic [AW-1:0] index_val = '0;
   logic [AW-1:0] base_val = '0;
   logic          busy, done, mem_req, wb_valid;
   logic [DW-1:0] operand, wb_value;
   logic [AW-1:0] eff_addr, mem_addr;
   logic [2:0]    wb_reg;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int reads   = 0;
   int dones   = 0;
   int cycles  = 0;
   int wait_c  = 0;
   int target  = 0;

   always #2 clk = ~clk;

   opaddr_gen #(.AW(AW), .DW(DW), .NREGS(8)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size_sel(size_sel),
      .addr_field(addr_field), .reg_sel(reg_sel), .reg_val(reg_val), .pc(pc),
      .index_val(index_val), .base_val(base_val), .busy(busy), .done(done),
      .operand(operand), .eff_addr(eff_addr), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value)
   );

   function automatic logic [15:0] memf(input logic [15:0] a);
      logic [31:0] p;
      p = a * 32'd40503;
      return p[15:0] ^ 16'h3c5a;
   endfunction

   function automatic logic [15:0] stepf(input logic [1:0] s);
      return (s == 2'd0) ? 16'd1 : (s == 2'd1) ? 16'd2 : 16'd4;
   endfunction

   // memory model with random response latency
   always @(negedge clk) begin
      cycles = cycles + 1;
      if (done) dones = dones + 1;
      if (mem_rvalid) begin
         mem_rvalid = 1'b0;
      end else if (mem_req) begin
         if (wait_c < target) wait_c = wait_c + 1;
         else begin
            mem_rvalid = 1'b1;
            mem_rdata  = memf(mem_addr);
            reads      = reads + 1;
            wait_c     = 0;
            target     = int'($urandom % 4);
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input string req, input logic [3:0] m, input logic [1:0] sz,
                         input logic [15:0] fld, input logic [2:0] rs,
                         input logic [15:0] rv, input logic [15:0] p,
                         input logic [15:0] ix, input logic [15:0] bs);
      logic [15:0] ea, op, wbv;
      int          nrd, t;
      logic        wbe;
      ea = '0; op = '0; wbv = '0; nrd = 1; wbe = 1'b0;
      case (m)
         4'd1: begin ea = fld; end
         4'd2: begin ea = memf(fld); nrd = 2; end
         4'd3: begin op = rv; nrd = 0; end
         4'd4: ea = rv;
         4'd5: ea = p + fld;
         4'd6: ea = ix + fld;
         4'd7: ea = bs + fld;
         4'd8: begin ea = rv; wbe = 1'b1; wbv = rv + stepf(sz); end
         4'd9: begin wbv = rv - stepf(sz); ea = wbv; wbe = 1'b1; end
         default: begin op = fld; nrd = 0; end
      endcase
      if (nrd != 0) op = memf(ea);
      mode = m; size_sel = sz; addr_field = fld; reg_sel = rs; reg_val = rv;
      pc = p; index_val = ix; base_val = bs;
      reads = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 100) begin
         @(negedge clk);
         t++;
      end
      chk(req, "done seen", {31'd0, done}, 32'd1);
      chk(req, "operand", {16'd0, operand}, {16'd0, op});
      chk(req, "eff_addr", {16'd0, eff_addr}, {16'd0, ea});
      chk(req, "reads", reads, nrd);
      chk(req, "wb_valid", {31'd0, wb_valid}, {31'd0, wbe});
      if (wbe) begin
         chk(req, "wb_value", {16'd0, wb_value}, {16'd0, wbv});
         chk(req, "wb_reg", {29'd0, wb_reg}, {29'd0, rs});
      end
      @(negedge clk);
      chk("R13", "done one cycle", {31'd0, done}, 32'd0);
   endtask

   // watchdog
   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "done", {31'd0, done}, 32'd0);
      chk("R1", "busy", {31'd0, busy}, 32'd0);
      chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1", "wb_valid", {31'd0, wb_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_op("R2", 4'd0, 2'd0, 16'hbeef, 3'd0, 16'h1111, 16'h0, 16'h0, 16'h0);
      run_op("R2", 4'd13, 2'd0, 16'h0042, 3'd0, 16'h1111, 16'h0, 16'h0, 16'h0);
      run_op("R3", 4'd3, 2'd1, 16'h0000, 3'd5, 16'hcafe, 16'h0, 16'h0, 16'h0);
      run_op("R4", 4'd1, 2'd0, 16'h0123, 3'd0, 16'h0, 16'h0, 16'h0, 16'h0);
      run_op("R5", 4'd2, 2'd0, 16'h0777, 3'd0, 16'h0, 16'h0, 16'h0, 16'h0);
      run_op("R6", 4'd4, 2'd0, 16'h0000, 3'd2, 16'h4000, 16'h0, 16'h0, 16'h0);
      run_op("R7", 4'd5, 2'd0, 16'h0020, 3'd0, 16'h0, 16'hfff0, 16'h0, 16'h0);
      run_op("R8", 4'd6, 2'd0, 16'h0010, 3'd0, 16'h0, 16'h0, 16'h0200, 16'h9000);
      run_op("R8", 4'd7, 2'd0, 16'h0010, 3'd0, 16'h0, 16'h0, 16'h0200, 16'h9000);
      run_op("R9", 4'd8, 2'd1, 16'h0000, 3'd6, 16'd3300, 16'h0, 16'h0, 16'h0);
      run_op("R10", 4'd9, 2'd1, 16'h0000, 3'd1, 16'd3302, 16'h0, 16'h0, 16'h0);
      run_op("R11", 4'd8, 2'd0, 16'h0000, 3'd3, 16'hffff, 16'h0, 16'h0, 16'h0);
      run_op("R11", 4'd9, 2'd2, 16'h0000, 3'd4, 16'h0002, 16'h0, 16'h0, 16'h0);
      run_op("R11", 4'd8, 2'd3, 16'h0000, 3'd7, 16'h1000, 16'h0, 16'h0, 16'h0);

      // R13: start while busy is ignored
      begin
         int d0, t;
         d0 = dones;
         mode = 4'd1; addr_field = 16'h0555; start = 1'b1;
         @(negedge clk);
         mode = 4'd0; addr_field = 16'h00aa;
         @(negedge clk);
         start = 1'b0;
         t = 0;
         while (!done && t < 100) begin
            @(negedge clk);
            t++;
         end
         chk("R13", "first result kept", {16'd0, operand}, {16'd0, memf(16'h0555)});
         repeat (10) @(negedge clk);
         chk("R13", "single done", dones - d0, 1);
      end

      // R12 is also watched by the address-hold assertion under random latency
      for (int i = 0; i < 80; i++) begin
         logic [3:0] m;
         m = 4'($urandom % 12);
         run_op("R12", m, 2'($urandom), 16'($urandom), 3'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule